// File: doc/BRIEF.md
# Instruction Group Issue Stage

This block sits between instruction fetch and the execution units of a wide in-order core. Each cycle it can take one 128-bit bundle. A bundle holds three 41-bit instructions and a 5-bit template. The template gives each slot a unit class and marks where a stop follows a slot. A stop closes an issue group. The instructions inside one group carry no register hazards between them, so the block does no dependency checking. It only has to find where each group starts and ends.

Accepted instructions go into a short slot queue. Each cycle the block looks at the head of the queue and issues the leading group across up to `ISSUE_W` output lanes. Each lane carries a valid flag, the 41-bit instruction and its 2-bit unit class. A group may span several bundles. A group longer than the lane count is split over consecutive cycles. The block holds a partial group until it sees the stop or until it has enough slots to fill every lane. The bundle stream must therefore close its last group with a stop. There is no downstream backpressure: lanes that are valid in a cycle are consumed at the next clock edge.

Top module: `bundle_disperser`

## Requirements
- R1: While reset is high and in the first cycle after it falls, every lane is invalid, in_ready is high, and the queue is empty.
- R2: Template bits [4:0]; instruction slot k sits at bits [5+41k +: 41]. Template bits [4:3] choose the unit classes (codes integer=0, memory=1, branch=2, floating=3) of slots 0, 1 and 2: 00 gives memory, integer, integer; 01 gives memory, memory, integer; 10 gives memory, floating, integer; 11 gives memory, integer, branch. Each issued lane shows the instruction and class of its slot.
- R3: Template bit k set means a stop follows slot k. An issued group ends at the first stop in the queue. The slot after that stop is issued in lane 0 of a later cycle.
- R4: If slot 2 of a bundle has no stop, its group goes on into the next bundle, and slots from both bundles issue in the same cycle.
- R5: No more than ISSUE_W (default 6) lanes are valid in a cycle. A stretch with no stop that reaches ISSUE_W queued slots is issued ISSUE_W at a time.
- R6: When fewer than ISSUE_W slots are queued and none of them carries a stop, nothing is issued.
- R7: The queue holds ISSUE_W+2 slots. in_ready is high exactly when at least three entries are free. A bundle presented while in_ready is low is not taken and has no effect on later lanes.
- R8: Valid lanes are contiguous from lane 0, and instructions appear in stream order, both within a cycle and across cycles.
- R9: A group that becomes complete when a bundle is accepted at a clock edge is shown on the lanes right after that edge. The lanes are consumed at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Bundle offered |
| in_ready | output | 1 | Queue can take a bundle |
| in_bundle | input | 128 | Template plus three instruction slots |
| out_valid | output | ISSUE_W | Per-lane issue flag |
| out_insn | output | ISSUE_W*41 | Lane i instruction at bits [41i +: 41] |
| out_unit | output | ISSUE_W*2 | Lane i unit class at bits [2i +: 2] |

## Verification
A queue count that drifts shows up in the first cycle after it goes wrong. in_ready changes at the wrong occupancy, or the lanes repeat or skip instructions, so every later instruction compared against the bench model comes out wrong. A stop scan that is wrong shows at once as a group boundary in the wrong place, or as a stall that should not be there. A broken shift or append puts the wrong instruction word or unit class on a lane in the same cycle that group issues.

// File: rtl/bundle_disp_pkg.sv
package bundle_disp_pkg;

    localparam int BUNDLE_W  = 128;
    localparam int INSN_W    = 41;
    localparam int TMPL_W    = 5;
    localparam int SLOTS_PB  = 3;

    typedef enum logic [1:0] {
        UNIT_INT = 2'd0,
        UNIT_MEM = 2'd1,
        UNIT_BR  = 2'd2,
        UNIT_FP  = 2'd3
    } unit_e;

    typedef struct packed {
        logic [INSN_W-1:0] insn;
        unit_e             unit;
        logic              stop;
    } slot_t;

    // Unit class of slot k for a two-bit template pattern.
    function automatic unit_e class_of(logic [1:0] pat, int k);
        unit_e u;
        if (k == 0)
            u = UNIT_MEM;
        else if (k == 1)
            u = (pat == 2'd1) ? UNIT_MEM : ((pat == 2'd2) ? UNIT_FP : UNIT_INT);
        else
            u = (pat == 2'd3) ? UNIT_BR : UNIT_INT;
        return u;
    endfunction

endpackage

// File: rtl/bundle_unpack.sv
module bundle_unpack
    import bundle_disp_pkg::*;
(
    input  logic [BUNDLE_W-1:0]   bundle,
    output slot_t [SLOTS_PB-1:0]  slots
);
    logic [TMPL_W-1:0] tmpl;
    assign tmpl = bundle[TMPL_W-1:0];

    for (genvar k = 0; k < SLOTS_PB; k++) begin : g_slot
        assign slots[k].insn = bundle[TMPL_W + k*INSN_W +: INSN_W];
        assign slots[k].unit = class_of(tmpl[4:3], k);
        assign slots[k].stop = tmpl[k];
    end
endmodule

// File: rtl/slot_queue.sv
module slot_queue
    import bundle_disp_pkg::*;
#(
    parameter int CAP  = 8,
    parameter int HEAD = 6,
    localparam int CW  = $clog2(CAP + 1),
    localparam int NW  = $clog2(HEAD + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  push,
    input  slot_t [SLOTS_PB-1:0]  push_slots,
    input  logic [NW-1:0]         pop_n,
    output slot_t [HEAD-1:0]      head,
    output logic [CW-1:0]         count
);
    slot_t [CAP-1:0] q_r, q_n;
    logic [CW-1:0]   cnt_n;

    always_comb begin
        int sh;
        int base;
        sh   = int'(pop_n);
        base = int'(count) - sh;
        for (int i = 0; i < CAP; i++) begin
            if (i + sh < CAP) q_n[i] = q_r[i + sh];
            else              q_n[i] = '0;
        end
        if (push) begin
            for (int k = 0; k < SLOTS_PB; k++)
                if (base + k < CAP) q_n[base + k] = push_slots[k];
        end
        cnt_n = CW'(base + (push ? SLOTS_PB : 0));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r   <= '0;
            count <= '0;
        end else begin
            q_r   <= q_n;
            count <= cnt_n;
        end
    end

    assign head = q_r[HEAD-1:0];

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(count) <= CAP);                                           // R7
    AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (rst)
        push |-> (CAP - int'(count)) >= SLOTS_PB);                     // R7
    AST_POP_AVAIL: assert property (@(posedge clk) disable iff (rst)
        int'(pop_n) <= int'(count));                                   // R8
endmodule

// File: rtl/group_picker.sv
module group_picker #(
    parameter int W   = 6,
    parameter int CW  = 4,
    localparam int NW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  stops,
    input  logic [CW-1:0] count,
    output logic [W-1:0]  lane_v,
    output logic [NW-1:0] n
);
    always_comb begin
        logic blocked;
        logic fire;
        logic [W-1:0] cand;
        int cnt;
        blocked = 1'b0;
        fire    = 1'b0;
        cand    = '0;
        cnt     = 0;
        for (int i = 0; i < W; i++) begin
            if (i < int'(count) && !blocked) begin
                cand[i] = 1'b1;
                cnt++;
                if (stops[i]) begin
                    fire    = 1'b1;
                    blocked = 1'b1;
                end
            end
        end
        if (int'(count) >= W) fire = 1'b1;
        lane_v = fire ? cand : '0;
        n      = fire ? NW'(cnt) : '0;
    end

    for (genvar i = 0; i < W - 1; i++) begin : g_chk
        AST_STOP_ENDS: assert property (@(posedge clk) disable iff (rst)
            (lane_v[i] && stops[i]) |-> !lane_v[i+1]);                 // R3
    end
endmodule

// File: rtl/bundle_disperser.sv
module bundle_disperser
    import bundle_disp_pkg::*;
#(
    parameter int ISSUE_W = 6,
    localparam int CAP    = ISSUE_W + SLOTS_PB - 1,
    localparam int CW     = $clog2(CAP + 1),
    localparam int NW     = $clog2(ISSUE_W + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [BUNDLE_W-1:0]         in_bundle,
    output logic [ISSUE_W-1:0]          out_valid,
    output logic [ISSUE_W*INSN_W-1:0]   out_insn,
    output logic [ISSUE_W*2-1:0]        out_unit
);
    slot_t [SLOTS_PB-1:0] new_slots;
    slot_t [ISSUE_W-1:0]  head;
    logic [CW-1:0]        count;
    logic [NW-1:0]        pop_n;
    logic [ISSUE_W-1:0]   stops;
    logic                 push;

    bundle_unpack u_unpack (
        .bundle (in_bundle),
        .slots  (new_slots)
    );

    assign in_ready = (CAP - int'(count)) >= SLOTS_PB;
    assign push     = in_valid && in_ready;

    slot_queue #(.CAP(CAP), .HEAD(ISSUE_W)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .push_slots (new_slots),
        .pop_n      (pop_n),
        .head       (head),
        .count      (count)
    );

    for (genvar i = 0; i < ISSUE_W; i++) begin : g_lane
        assign stops[i]                   = head[i].stop;
        assign out_insn[i*INSN_W +: INSN_W] = head[i].insn;
        assign out_unit[i*2 +: 2]           = head[i].unit;
    end

    group_picker #(.W(ISSUE_W), .CW(CW)) u_pick (
        .clk    (clk),
        .rst    (rst),
        .stops  (stops),
        .count  (count),
        .lane_v (out_valid),
        .n      (pop_n)
    );

    AST_LANES_CONTIG: assert property (@(posedge clk) disable iff (rst)
        (out_valid & (out_valid + 1'b1)) == '0);                       // R8
    AST_READY_AFTER_RESET: assert property (@(posedge clk)
        $fell(rst) |-> (in_ready && out_valid == '0));                 // R1
endmodule

// File: tb/bundle_disperser_tb.sv
module bundle_disperser_tb;
    localparam int W   = 6;
    localparam int CAP = W + 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [127:0]      in_bundle = '0;
    logic [W-1:0]      out_valid;
    logic [W*41-1:0]   out_insn;
    logic [W*2-1:0]    out_unit;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [40:0] m_insn [0:15];
    logic [1:0]  m_unit [0:15];
    logic        m_stop [0:15];
    int          mc = 0;

    always #5 clk = ~clk;

    bundle_disperser #(.ISSUE_W(W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_bundle(in_bundle), .out_valid(out_valid),
        .out_insn(out_insn), .out_unit(out_unit)
    );

    function automatic logic [1:0] exp_unit(logic [1:0] pat, int k);
        if (k == 0) return 2'd1;
        if (k == 1) return (pat == 2'd1) ? 2'd1 : ((pat == 2'd2) ? 2'd3 : 2'd0);
        return (pat == 2'd3) ? 2'd2 : 2'd0;
    endfunction

    function automatic logic [127:0] mk(logic [1:0] pat, logic [2:0] st);
        logic [40:0] a, b, c;
        a = {$urandom(), $urandom()};
        b = {$urandom(), $urandom()};
        c = {$urandom(), $urandom()};
        return {c, b, a, pat, st};
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic v, input logic [127:0] b, input string tag);
        bit exp_ready, fire, blk;
        int n;
        logic [W-1:0] ev;
        @(negedge clk);
        in_valid  = v;
        in_bundle = b;
        #1;
        exp_ready = (CAP - mc) >= 3;
        chk(in_ready == exp_ready, "R7 ready", 64'(in_ready), 64'(exp_ready));
        fire = 0; blk = 0; n = 0; ev = '0;
        for (int i = 0; i < W; i++) begin
            if (i < mc && !blk) begin
                ev[i] = 1'b1;
                n++;
                if (m_stop[i]) begin fire = 1; blk = 1; end
            end
        end
        if (mc >= W) fire = 1;
        if (!fire) begin ev = '0; n = 0; end
        chk(out_valid == ev, tag, 64'(out_valid), 64'(ev));
        chk((out_valid & (out_valid + 1'b1)) == '0, "R8 contiguous",
            64'(out_valid), 64'(ev));
        for (int i = 0; i < W; i++) begin
            if (ev[i]) begin
                chk(out_insn[i*41 +: 41] == m_insn[i], "R2 R8 insn",
                    64'(out_insn[i*41 +: 41]), 64'(m_insn[i]));
                chk(out_unit[i*2 +: 2] == m_unit[i], "R2 unit",
                    64'(out_unit[i*2 +: 2]), 64'(m_unit[i]));
            end
        end
        for (int j = 0; j < mc - n; j++) begin
            m_insn[j] = m_insn[j+n];
            m_unit[j] = m_unit[j+n];
            m_stop[j] = m_stop[j+n];
        end
        mc -= n;
        if (v && exp_ready) begin
            for (int k = 0; k < 3; k++) begin
                m_insn[mc+k] = b[5 + 41*k +: 41];
                m_unit[mc+k] = exp_unit(b[4:3], k);
                m_stop[mc+k] = b[k];
            end
            mc += 3;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1: reset state
        chk(out_valid == '0, "R1 lanes idle", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1 ready", 64'(in_ready), 64'd1);

        // R3: every slot its own group, all patterns
        for (int p = 0; p < 4; p++) step(1'b1, mk(2'(p), 3'b111), "R3 stop per slot");
        repeat (6) step(1'b0, '0, "R3 drain");

        // R6 then R4: no stop, hold, then group spans into next bundle
        step(1'b1, mk(2'd2, 3'b000), "R6 hold");
        repeat (4) step(1'b0, '0, "R6 hold no stop");
        step(1'b1, mk(2'd3, 3'b001), "R4 span");
        repeat (4) step(1'b0, '0, "R4 span drain");

        // R5: long stop-free run split at issue width, ready pressure (R7)
        repeat (5) step(1'b1, mk(2'd1, 3'b000), "R5 split");
        step(1'b1, mk(2'd0, 3'b100), "R5 close");
        repeat (6) step(1'b0, '0, "R5 drain");

        // R9: random stream, one-cycle visibility and ordering
        for (int t = 0; t < 3000; t++) begin
            logic [2:0] st;
            for (int k = 0; k < 3; k++) st[k] = ($urandom_range(2) == 0);
            step(($urandom_range(3) != 0), mk(2'($urandom_range(3)), st), "R9 random");
        end
        step(1'b1, mk(2'd0, 3'b111), "R9 flush");
        repeat (8) step(1'b0, '0, "R9 flush drain");
        chk(out_valid == '0, "R9 empty at end", 64'(out_valid), 64'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule